// File: doc/BRIEF.md
# Burst Memory Target for a Parallel Multiplexed Bus

This block sits on a PCI-style shared bus as a target. It holds a small dword memory. Bus masters read and write that memory in bursts of any length. The block watches for the start of each transaction, compares the address and command against its own window, and claims a matching transaction by asserting DEVSEL#. It then paces every data phase with TRDY#. Reads return memory words on the multiplexed address/data lines. Writes store the lanes that the byte enables select. The word pointer steps forward after each completed phase.

The block also answers configuration cycles when its IDSEL line is high. Only function zero is supported. Dword 0 of configuration space returns a fixed identification value, every other dword reads as zero, and configuration writes are accepted but discarded. The bus lines appear as separate input, output and output-enable signals, so the pads or the bus model above the block do the tri-stating.

Top module: `pci_mem_target`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high, AD is not driven (adOe low) and every memory word reads as zero.
- R2: A memory read (C/BE# = 4'h6) or memory write (C/BE# = 4'h7) is claimed only when its address lies in [BASE_ADDR, BASE_ADDR + 4*DEPTH_WORDS). DEVSEL# then goes low in the clock after the address phase. Any other command, or an address outside the window, is not claimed and leaves the memory unchanged.
- R3: On a read, the first clock after the address phase has DEVSEL# low, TRDY# high and AD not driven. In the next clock AD carries the addressed word and TRDY# is low.
- R4: On a write, TRDY# is low from the clock after the address phase. A data phase completes on an edge where IRDY# and TRDY# are both low. Byte lane n (AD[8n+7:8n]) is stored only when C/BE#[n] is low.
- R5: Each completed data phase advances the word pointer by one dword. The word index (address bits above bit 1) wraps modulo DEPTH_WORDS.
- R6: While IRDY# is high during a data phase, nothing completes. Read data on AD stays unchanged and no write is stored.
- R7: A data phase that completes with FRAME# high is the final one. In the following clock DEVSEL# and TRDY# are high and AD is released.
- R8: An address phase is recognised only when FRAME# is low and the previous rising edge saw FRAME# and IRDY# both high. AD and C/BE# values during another master's data phases are never decoded.
- R9: A configuration read (4'hA) or configuration write (4'hB) is claimed only with IDSEL high, AD[1:0] = 2'b00 and AD[10:8] = 3'b000. AD[7:2] selects the dword: dword 0 returns ID_WORD and all others return zero. Configuration writes change neither configuration reads nor memory.
- R10: STOP# is never driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| adIn | input | 32 | Multiplexed address/data as seen on the bus |
| cbeN | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frameN | input | 1 | Active-low transaction frame from the master |
| irdyN | input | 1 | Active-low master ready |
| idsel | input | 1 | Configuration select for this target |
| adOut | output | 32 | Read data to drive onto AD |
| adOe | output | 1 | High when the target drives AD |
| devselN | output | 1 | Active-low claim of the current transaction |
| trdyN | output | 1 | Active-low target ready |
| stopN | output | 1 | Active-low stop request, held high |

## Verification
Some rules are checked by the embedded properties on every clock. These are: the read turnaround after a claimed memory read, TRDY# never active without DEVSEL#, release of all target outputs after a final phase, no claim while the bus is still busy, and stable read data while the master stalls. Other behaviour shows only through the bench's transactions. This covers stored byte-lane merging, pointer advance and wrap at the top of the memory, rejection of foreign addresses, commands and bus-busy decodes, and the configuration space. These are confirmed by reading memory back through ordinary bursts against a reference model.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'h6;
  localparam logic [3:0] CMD_MEM_WR = 4'h7;
  localparam logic [3:0] CMD_CFG_RD = 4'hA;
  localparam logic [3:0] CMD_CFG_WR = 4'hB;

  // configuration dword select width (AD[7:2])
  localparam int CFG_IDX_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TURN  = 2'd1,
    ST_RDATA = 2'd2,
    ST_WDATA = 2'd3
  } tgtState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // latch address from AD this edge
    logic startCfg;  // claimed transaction targets configuration space
    logic advance;   // a data phase completes this edge
    logic wrEn;      // store write data this edge
  } tgtStrobe_t;

endpackage

// File: rtl/pci_tgt_datapath.sv
module pci_tgt_datapath
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
  parameter int          DEPTH_WORDS = 64,
  parameter logic [31:0] ID_WORD     = 32'h1234_5678
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        idsel,
  input  tgtStrobe_t  strobe,
  output logic        memHit,
  output logic        cfgHit,
  output logic [31:0] adOut
);

  localparam int         IDX_W     = $clog2(DEPTH_WORDS);
  localparam int         LANES     = 4;
  localparam logic [32:0] WIN_BYTES = 33'(DEPTH_WORDS) << 2;

  logic [32:0]          offset;
  logic [IDX_W-1:0]     wordIdx;
  logic [CFG_IDX_W-1:0] cfgIdx;
  logic                 cfgMode;
  logic [31:0]          wrMask;
  logic [31:0]          mem [DEPTH_WORDS];

  // address window and configuration decode
  assign offset = {1'b0, adIn} - {1'b0, BASE_ADDR};
  assign memHit = !offset[32] && (offset < WIN_BYTES);
  assign cfgHit = idsel && (adIn[1:0] == 2'b00) && (adIn[10:8] == 3'b000);

  // per-lane write mask from active-low byte enables
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign wrMask[8*g +: 8] = {8{~cbeN[g]}};
  end

  // burst pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx <= '0;
      cfgIdx  <= '0;
      cfgMode <= 1'b0;
    end else if (strobe.start) begin
      wordIdx <= adIn[IDX_W+1:2];
      cfgIdx  <= adIn[7:2];
      cfgMode <= strobe.startCfg;
    end else if (strobe.advance) begin
      wordIdx <= wordIdx + 1'b1;
      cfgIdx  <= cfgIdx + 1'b1;
    end
  end

  // storage; configuration writes are discarded
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH_WORDS; i++) mem[i] <= '0;
    end else if (strobe.wrEn && !cfgMode) begin
      mem[wordIdx] <= (mem[wordIdx] & ~wrMask) | (adIn & wrMask);
    end
  end

  // read return
  always_comb begin
    if (cfgMode) adOut = (cfgIdx == '0) ? ID_WORD : 32'h0;
    else         adOut = mem[wordIdx];
  end

endmodule

// File: rtl/pci_tgt_ctrl.sv
module pci_tgt_ctrl
  import pci_tgt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameN,
  input  logic       irdyN,
  input  logic [3:0] cbeN,
  input  logic       memHit,
  input  logic       cfgHit,
  output tgtStrobe_t strobe,
  output logic       devselN,
  output logic       trdyN,
  output logic       adOe
);

  tgtState_t state, stateNext;
  logic busIdlePrev;
  logic addrPhase, memRd, memWr, cfgRd, cfgWr, claimRd, claimWr;
  logic xfer, lastXfer;

  assign addrPhase = (state == ST_IDLE) && busIdlePrev && !frameN;
  assign memRd     = (cbeN == CMD_MEM_RD) && memHit;
  assign memWr     = (cbeN == CMD_MEM_WR) && memHit;
  assign cfgRd     = (cbeN == CMD_CFG_RD) && cfgHit;
  assign cfgWr     = (cbeN == CMD_CFG_WR) && cfgHit;
  assign claimRd   = memRd || cfgRd;
  assign claimWr   = memWr || cfgWr;
  assign xfer      = !irdyN && !trdyN;
  assign lastXfer  = xfer && frameN;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (addrPhase && claimRd)      stateNext = ST_TURN;
        else if (addrPhase && claimWr) stateNext = ST_WDATA;
      end
      ST_TURN:  stateNext = ST_RDATA;
      ST_RDATA: if (lastXfer) stateNext = ST_IDLE;
      ST_WDATA: if (lastXfer) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign strobe.start    = addrPhase && (claimRd || claimWr);
  assign strobe.startCfg = cfgRd || cfgWr;
  assign strobe.advance  = xfer;
  assign strobe.wrEn     = xfer && (state == ST_WDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      busIdlePrev <= 1'b0;
      devselN     <= 1'b1;
      trdyN       <= 1'b1;
      adOe        <= 1'b0;
    end else begin
      state       <= stateNext;
      busIdlePrev <= frameN && irdyN;
      devselN     <= (stateNext == ST_IDLE);
      trdyN       <= !((stateNext == ST_RDATA) || (stateNext == ST_WDATA));
      adOe        <= (stateNext == ST_RDATA);
    end
  end

  // claimed memory read: turnaround clock with AD released, TRDY# high
  assert_read_turnaround_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && busIdlePrev && !frameN && cbeN == CMD_MEM_RD && memHit)
      |=> (!devselN && trdyN && !adOe));

  // target ready only inside a claimed transaction
  assert_trdy_within_devsel_R7: assert property (@(posedge clk) disable iff (!rstN)
    !trdyN |-> !devselN);

  // final phase releases everything
  assert_release_after_last_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!trdyN && !irdyN && frameN) |=> (devselN && trdyN && !adOe));

  // no claim unless the bus was seen idle
  assert_no_claim_when_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !busIdlePrev) |=> devselN);

endmodule

// File: rtl/pci_mem_target.sv
module pci_mem_target
  import pci_tgt_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
  parameter int          DEPTH_WORDS = 64,
  parameter logic [31:0] ID_WORD     = 32'h1234_5678
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] adIn,
  input  logic [3:0]  cbeN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        idsel,
  output logic [31:0] adOut,
  output logic        adOe,
  output logic        devselN,
  output logic        trdyN,
  output logic        stopN
);

  tgtStrobe_t strobe;
  logic memHit, cfgHit;

  assign stopN = 1'b1;

  pci_tgt_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .frameN  (frameN),
    .irdyN   (irdyN),
    .cbeN    (cbeN),
    .memHit  (memHit),
    .cfgHit  (cfgHit),
    .strobe  (strobe),
    .devselN (devselN),
    .trdyN   (trdyN),
    .adOe    (adOe)
  );

  pci_tgt_datapath #(
    .BASE_ADDR   (BASE_ADDR),
    .DEPTH_WORDS (DEPTH_WORDS),
    .ID_WORD     (ID_WORD)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .adIn   (adIn),
    .cbeN   (cbeN),
    .idsel  (idsel),
    .strobe (strobe),
    .memHit (memHit),
    .cfgHit (cfgHit),
    .adOut  (adOut)
  );

  // master stall during a read data phase holds the driven word
  assert_read_hold_on_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && !trdyN && irdyN) |=> ($stable(adOut) && adOe));

endmodule

// File: tb/pci_mem_target_tb.sv
`timescale 1ns/1ps
module pci_mem_target_tb;

  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam int          DEPTH = 64;
  localparam logic [31:0] IDW   = 32'hC0DE_0001;

  typedef struct packed {
    logic        wr;
    logic [5:0]  idx;
    logic [31:0] data;
    logic [3:0]  be;
    logic [31:0] exp;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd3,  32'h5555_5555, 4'b0000, 32'h0},
    '{1'b0, 6'd3,  32'h0,         4'b0000, 32'h5555_5555},
    '{1'b1, 6'd3,  32'hAAAA_AAAA, 4'b1100, 32'h0},
    '{1'b0, 6'd3,  32'h0,         4'b0000, 32'h5555_AAAA},
    '{1'b1, 6'd10, 32'h0F0F_0F0F, 4'b0000, 32'h0},
    '{1'b1, 6'd10, 32'hFFFF_FFFF, 4'b1110, 32'h0},
    '{1'b0, 6'd10, 32'h0,         4'b0000, 32'h0F0F_0FFF},
    '{1'b1, 6'd63, 32'h5A5A_5A5A, 4'b0000, 32'h0},
    '{1'b0, 6'd63, 32'h0,         4'b0000, 32'h5A5A_5A5A},
    '{1'b1, 6'd0,  32'h00FF_00FF, 4'b1011, 32'h0},
    '{1'b0, 6'd0,  32'h0,         4'b0000, 32'h00FF_0000},
    '{1'b0, 6'd5,  32'h0,         4'b0000, 32'h0}
  };

  logic        clk, rstN;
  logic [31:0] adIn;
  logic [3:0]  cbeN;
  logic        frameN, irdyN, idsel;
  logic [31:0] adOut;
  logic        adOe, devselN, trdyN, stopN;

  int vecCount;
  int missCount;
  logic [31:0] model  [DEPTH];
  logic [31:0] wrData [8];
  logic [3:0]  wrBe   [8];
  logic [31:0] rdExp  [8];

  pci_mem_target #(
    .BASE_ADDR   (BASE),
    .DEPTH_WORDS (DEPTH),
    .ID_WORD     (IDW)
  ) u_dut (
    .clk (clk), .rstN (rstN), .adIn (adIn), .cbeN (cbeN),
    .frameN (frameN), .irdyN (irdyN), .idsel (idsel),
    .adOut (adOut), .adOe (adOe), .devselN (devselN),
    .trdyN (trdyN), .stopN (stopN)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    check(req, {31'b0, act}, {31'b0, exp});
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int l = 0; l < 4; l++) if (!be[l]) r[8*l +: 8] = nw[8*l +: 8];
    return r;
  endfunction

  task automatic busIdle();
    frameN = 1'b1; irdyN = 1'b1; idsel = 1'b0; adIn = '0; cbeN = 4'hF;
    @(negedge clk);
  endtask

  task automatic doWrite(input logic [31:0] addr, input int n, input int stallAt,
                         input logic [3:0] cmd, input logic idselV, input bit expClaim,
                         input string req);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = idselV;
    @(negedge clk);
    idsel = 1'b0;
    checkBit({req, " devsel"}, devselN, !expClaim);
    checkBit({req, " trdy"}, trdyN, !expClaim);
    for (int k = 0; k < n; k++) begin
      if (k == stallAt) begin
        irdyN = 1'b1; frameN = 1'b0; adIn = 32'hDEAD_BEEF; cbeN = 4'h0;
        @(negedge clk);
      end
      adIn = wrData[k]; cbeN = wrBe[k]; irdyN = 1'b0; frameN = (k == n - 1);
      @(negedge clk);
    end
    checkBit("R7 write end devsel", devselN, 1'b1);
    checkBit("R7 write end trdy", trdyN, 1'b1);
    busIdle();
  endtask

  task automatic doRead(input logic [31:0] addr, input int n, input int stallAt,
                        input logic [3:0] cmd, input logic idselV, input string req);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = idselV;
    @(negedge clk);
    idsel = 1'b0;
    checkBit("R3 turnaround devsel", devselN, 1'b0);
    checkBit("R3 turnaround trdy", trdyN, 1'b1);
    checkBit("R3 turnaround AD released", adOe, 1'b0);
    adIn = '0; cbeN = 4'h0; irdyN = 1'b0; frameN = (n == 1);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (k == stallAt) begin
        irdyN = 1'b1; frameN = 1'b0;
        check({req, " before stall"}, adOut, rdExp[k]);
        @(negedge clk);
        check("R6 read data held in stall", adOut, rdExp[k]);
        checkBit("R6 trdy held in stall", trdyN, 1'b0);
        irdyN = 1'b0;
      end
      check(req, adOut, rdExp[k]);
      checkBit("R3 AD driven in data phase", adOe, 1'b1);
      frameN = (k == n - 1);
      @(negedge clk);
    end
    checkBit("R7 read end devsel", devselN, 1'b1);
    checkBit("R7 read end trdy", trdyN, 1'b1);
    checkBit("R7 read end AD released", adOe, 1'b0);
    checkBit("R10 stop never asserted", stopN, 1'b1);
    busIdle();
  endtask

  task automatic probeNoClaim(input logic [31:0] addr, input logic [3:0] cmd,
                              input logic idselV, input string req);
    frameN = 1'b0; irdyN = 1'b1; adIn = addr; cbeN = cmd; idsel = idselV;
    @(negedge clk);
    idsel = 1'b0;
    checkBit(req, devselN, 1'b1);
    irdyN = 1'b0; frameN = 1'b1; adIn = 32'hFFFF_FFFF; cbeN = 4'h0;
    @(negedge clk);
    checkBit(req, devselN, 1'b1);
    checkBit(req, trdyN, 1'b1);
    checkBit(req, adOe, 1'b0);
    busIdle();
  endtask

  task automatic readModel(input int idx, input string req);
    rdExp[0] = model[idx];
    doRead(BASE + 32'(idx) * 4, 1, -1, 4'h6, 1'b0, req);
  endtask

  initial begin
    vecCount = 0; missCount = 0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    rstN = 1'b0; frameN = 1'b1; irdyN = 1'b1; idsel = 1'b0; adIn = '0; cbeN = 4'hF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkBit("R1 reset devsel", devselN, 1'b1);
    checkBit("R1 reset trdy", trdyN, 1'b1);
    checkBit("R1 reset stop", stopN, 1'b1);
    checkBit("R1 reset AD released", adOe, 1'b0);
    busIdle();

    // table of single-beat accesses (R2, R4, R1 for the untouched word)
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].wr) begin
        wrData[0] = VECS[v].data; wrBe[0] = VECS[v].be;
        doWrite(BASE + 32'(VECS[v].idx) * 4, 1, -1, 4'h7, 1'b0, 1'b1, "R4 table write");
        model[VECS[v].idx] = merge(model[VECS[v].idx], VECS[v].data, VECS[v].be);
      end else begin
        rdExp[0] = VECS[v].exp;
        doRead(BASE + 32'(VECS[v].idx) * 4, 1, -1, 4'h6, 1'b0, "R4 R1 table read");
      end
    end

    // R5 R6: four-beat write with a master stall, then four-beat read with a stall
    wrData[0] = 32'h0000_0000; wrData[1] = 32'h5555_5555;
    wrData[2] = 32'hAAAA_AAAA; wrData[3] = 32'hFFFF_FFFF;
    for (int k = 0; k < 4; k++) wrBe[k] = 4'h0;
    doWrite(BASE + 32'd80, 4, 2, 4'h7, 1'b0, 1'b1, "R5 burst write");
    for (int k = 0; k < 4; k++) model[20 + k] = wrData[k];
    for (int k = 0; k < 4; k++) rdExp[k] = model[20 + k];
    doRead(BASE + 32'd80, 4, 1, 4'h6, 1'b0, "R5 burst read");

    // R5 wrap at the top of the memory
    wrData[0] = 32'h1111_1111; wrData[1] = 32'h2222_2222;
    wrBe[0] = 4'h0; wrBe[1] = 4'h0;
    doWrite(BASE + 32'd252, 2, -1, 4'h7, 1'b0, 1'b1, "R5 wrap write");
    model[63] = wrData[0]; model[0] = wrData[1];
    readModel(0, "R5 wrapped word");
    rdExp[0] = model[63]; rdExp[1] = model[0];
    doRead(BASE + 32'd252, 2, -1, 4'h6, 1'b0, "R5 wrap read");

    // R2 out-of-window and wrong-command writes are ignored
    wrData[0] = 32'hDEAD_BEEF; wrBe[0] = 4'h0;
    doWrite(BASE + 32'(DEPTH) * 4, 1, -1, 4'h7, 1'b0, 1'b0, "R2 above window");
    doWrite(BASE - 32'd4, 1, -1, 4'h7, 1'b0, 1'b0, "R2 below window");
    doWrite(BASE, 1, -1, 4'h3, 1'b0, 1'b0, "R2 wrong command");
    readModel(0, "R2 memory untouched");
    readModel(63, "R2 memory untouched top");
    probeNoClaim(BASE + 32'h1000, 4'h6, 1'b0, "R2 read outside window");

    // R8 another master's burst whose data phase looks like our address phase
    frameN = 1'b0; irdyN = 1'b1; adIn = 32'h8000_0000; cbeN = 4'h7;
    @(negedge clk);
    checkBit("R8 foreign address", devselN, 1'b1);
    irdyN = 1'b0; adIn = BASE; cbeN = 4'h7;
    @(negedge clk);
    checkBit("R8 data phase not decoded", devselN, 1'b1);
    checkBit("R8 data phase not decoded trdy", trdyN, 1'b1);
    adIn = BASE + 32'd4;
    @(negedge clk);
    checkBit("R8 second data phase", devselN, 1'b1);
    frameN = 1'b1;
    @(negedge clk);
    checkBit("R8 final foreign phase", devselN, 1'b1);
    busIdle();
    readModel(0, "R8 memory untouched");

    // R9 configuration space
    rdExp[0] = IDW; rdExp[1] = 32'h0;
    doRead(32'h0, 2, -1, 4'hA, 1'b1, "R9 config burst read");
    wrData[0] = 32'hFFFF_FFFF; wrBe[0] = 4'h0;
    doWrite(32'h0, 1, -1, 4'hB, 1'b1, 1'b1, "R9 config write claimed");
    rdExp[0] = IDW;
    doRead(32'h0, 1, -1, 4'hA, 1'b1, "R9 config read after write");
    readModel(0, "R9 config write left memory");
    probeNoClaim(32'h0, 4'hA, 1'b0, "R9 no idsel");
    probeNoClaim(32'h100, 4'hA, 1'b1, "R9 function one");

    // R1 reset in mid-run clears memory
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    busIdle();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    readModel(20, "R1 memory cleared by reset");
    readModel(63, "R1 memory cleared by reset top");

    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule